// File: doc/BRIEF.md
# Flash Identifier and Query Read Responder

This block supplies the read data for a parallel flash front end while the flash sits in identifier mode or in query mode. It takes the bus byte offset of a read, the read size, and three width settings (bank width, device width, largest device width), each given as a log2 code. It turns the offset into a table index and looks up either a manufacturer or device code or a byte of the query table. It then copies that device's answer across every device lane of the bank. A read wider than the bank is filled from several lookups at consecutive bank-sized steps.

The response is built combinationally and registered, so data appears on the read bus one clock after the request. This is the same slot an array read would use. The query table is fixed by parameters, except the buffer-size entry, which follows the bank width. The block also reports the buffered-write block size that the current width settings imply.

Width codes: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. Mode codes: 1 is identifier mode, 2 is query mode, and 0 or 3 is any other mode.

Top module: `flash_query_resp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rd_valid` is 0 and `rd_data` is 0.
- R2: `rd_valid` equals the `rd_en` of the previous cycle. `rd_data` is 0 when `rd_valid` is 0. A request made with mode code 0 or 3 returns 0.
- R3: The table index is `byte_off` shifted right by bank_lg + maxdev_lg − dev_lg.
- R4: In query mode, an index of 0x52 or more returns 0, even when its low 8 bits name a filled entry.
- R5: Query entries 0x10, 0x11 and 0x12 are 0x51, 0x52 and 0x59, and entry 0x13 is 0x01. Entry 0x2C is 0x01. Entry 0x2A is 8 for a 1-byte bank and 11 for a wider bank.
- R6: In query mode with a device width below the largest device width, a device width of 1 byte puts the entry byte into every byte of the bank. Any other device width returns 0.
- R7: When device width equals the largest device width, the entry is zero-extended to one device slice, and that slice is repeated in every device slice of the bank.
- R8: In identifier mode, the low 8 bits of the index select the answer: 0 gives MANUF_ID and 1 gives DEVICE_ID, each cut to the device width and repeated in every device slice of the bank. Every other value gives 0.
- R9: For a read larger than the bank, lookup k uses offset `byte_off` + k·bank bytes and lands at byte k·bank. For a read no larger than the bank, only the low read-size bytes of the single lookup appear. Bytes above the read size are 0.
- R10: One cycle after any clock out of reset, `buf_blk_bytes` equals 2^(entry 0x2A) × (bank width / device width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request this cycle |
| mode | input | 2 | 1 identifier, 2 query, other values give zero data |
| byte_off | input | OFF_W | Bus byte offset of the read |
| bank_lg | input | 2 | log2 of bank width in bytes |
| dev_lg | input | 2 | log2 of device width in bytes |
| maxdev_lg | input | 2 | log2 of largest device width in bytes |
| rd_lg | input | 2 | log2 of read size in bytes |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, byte 0 in bits 7:0 |
| buf_blk_bytes | output | 14 | Buffered-write block size in bytes |

## Verification
A wrong shift amount or a bad index compare shows up as a wrong or nonzero byte on `rd_data` one clock after the request. A bad lane copy or a bad lane packing breaks the byte pattern in that same read. Out-of-range query offsets, whose low 8 bits alias to filled entries, expose index truncation at once. A stale or miscomputed block size appears on `buf_blk_bytes` one cycle after the width settings change.

// File: rtl/flq_pkg.sv
package flq_pkg;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int BLK_W   = 14;
    localparam int TBL_LEN = 82;

    localparam logic [1:0] FQ_IDENT = 2'd1;
    localparam logic [1:0] FQ_QUERY = 2'd2;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [BLK_W-1:0]  blk;
    } fq_state_t;
endpackage

// File: rtl/qry_rom.sv
module qry_rom #(
    parameter int DEV_BLOCKS       = 64,
    parameter int DEV_SECTOR_BYTES = 65536
) (
    input  logic [7:0] idx_i,
    input  logic       wide_bank_i,
    output logic [7:0] byte_o
);
    localparam int SIZE_LG = $clog2(DEV_BLOCKS * DEV_SECTOR_BYTES);
    localparam int BLK_M1  = DEV_BLOCKS - 1;

    always_comb begin
        case (idx_i)
            8'h10: byte_o = 8'h51;
            8'h11: byte_o = 8'h52;
            8'h12: byte_o = 8'h59;
            8'h13: byte_o = 8'h01;
            8'h15: byte_o = 8'h31;
            8'h1B: byte_o = 8'h45;
            8'h1C: byte_o = 8'h55;
            8'h1F: byte_o = 8'h07;
            8'h20: byte_o = 8'h07;
            8'h21: byte_o = 8'h0A;
            8'h23: byte_o = 8'h04;
            8'h24: byte_o = 8'h04;
            8'h25: byte_o = 8'h04;
            8'h27: byte_o = 8'(SIZE_LG);
            8'h28: byte_o = 8'h02;
            8'h2A: byte_o = wide_bank_i ? 8'h0B : 8'h08;
            8'h2C: byte_o = 8'h01;
            8'h2D: byte_o = 8'(BLK_M1);
            8'h2E: byte_o = 8'(BLK_M1 >> 8);
            8'h2F: byte_o = 8'(DEV_SECTOR_BYTES >> 8);
            8'h30: byte_o = 8'(DEV_SECTOR_BYTES >> 16);
            8'h31: byte_o = 8'h50;
            8'h32: byte_o = 8'h52;
            8'h33: byte_o = 8'h49;
            8'h34: byte_o = 8'h31;
            default: byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/lane_lookup.sv
module lane_lookup
    import flq_pkg::*;
#(
    parameter int          OFF_W            = 16,
    parameter logic [31:0] MANUF_ID         = 32'h0000_0089,
    parameter logic [31:0] DEVICE_ID        = 32'h0000_0018,
    parameter int          DEV_BLOCKS       = 64,
    parameter int          DEV_SECTOR_BYTES = 65536
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        bank_lg_i,
    input  logic [1:0]        dev_lg_i,
    input  logic [1:0]        maxdev_lg_i,
    output logic [DATA_W-1:0] resp_o
);
    logic [2:0]        width_sum;
    logic [2:0]        shamt;
    logic [OFF_W-1:0]  idx_full;
    logic              in_tbl;
    logic [7:0]        entry;
    logic [DATA_W-1:0] slice;
    logic [1:0]        dev_mask;
    logic [1:0]        bank_m1;

    qry_rom #(
        .DEV_BLOCKS       (DEV_BLOCKS),
        .DEV_SECTOR_BYTES (DEV_SECTOR_BYTES)
    ) u_rom (
        .idx_i       (idx_full[7:0]),
        .wide_bank_i (bank_lg_i != 2'd0),
        .byte_o      (entry)
    );

    always_comb begin
        width_sum = {1'b0, bank_lg_i} + {1'b0, maxdev_lg_i};
        shamt     = (width_sum >= {1'b0, dev_lg_i}) ? (width_sum - {1'b0, dev_lg_i}) : 3'd0;
        idx_full  = off_i >> shamt;
        in_tbl    = idx_full < OFF_W'(TBL_LEN);
        dev_mask  = (dev_lg_i == 2'd0) ? 2'd0 : ((dev_lg_i == 2'd1) ? 2'd1 : 2'd3);
        bank_m1   = (bank_lg_i == 2'd0) ? 2'd0 : ((bank_lg_i == 2'd1) ? 2'd1 : 2'd3);

        slice = '0;
        if (mode_i == FQ_IDENT) begin
            if (idx_full[7:0] == 8'd0)      slice = MANUF_ID;
            else if (idx_full[7:0] == 8'd1) slice = DEVICE_ID;
        end else if (mode_i == FQ_QUERY && in_tbl) begin
            if (dev_lg_i < maxdev_lg_i) begin
                if (dev_lg_i == 2'd0) slice = {24'd0, entry};
            end else begin
                slice = {24'd0, entry};
            end
        end

        resp_o = '0;
        for (int b = 0; b < LANES; b++) begin
            if (2'(b) <= bank_m1) begin
                resp_o[8*b +: 8] = slice[8*int'(2'(b) & dev_mask) +: 8];
            end
        end
    end
endmodule

// File: rtl/flash_query_resp.sv
module flash_query_resp
    import flq_pkg::*;
#(
    parameter int          OFF_W            = 16,
    parameter logic [31:0] MANUF_ID         = 32'h0000_0089,
    parameter logic [31:0] DEVICE_ID        = 32'h0000_0018,
    parameter int          DEV_BLOCKS       = 64,
    parameter int          DEV_SECTOR_BYTES = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [1:0]        mode,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        maxdev_lg,
    input  logic [1:0]        rd_lg,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic [13:0]       buf_blk_bytes
);
    logic [DATA_W-1:0] lane_resp [LANES];
    fq_state_t         st_d, st_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OFF_W-1:0] lane_off;
        assign lane_off = byte_off + (OFF_W'(k) << bank_lg);
        lane_lookup #(
            .OFF_W            (OFF_W),
            .MANUF_ID         (MANUF_ID),
            .DEVICE_ID        (DEVICE_ID),
            .DEV_BLOCKS       (DEV_BLOCKS),
            .DEV_SECTOR_BYTES (DEV_SECTOR_BYTES)
        ) u_lane (
            .off_i       (lane_off),
            .mode_i      (mode),
            .bank_lg_i   (bank_lg),
            .dev_lg_i    (dev_lg),
            .maxdev_lg_i (maxdev_lg),
            .resp_o      (lane_resp[k])
        );
    end

    always_comb begin
        logic [1:0]        rd_m1;
        logic [1:0]        bank_mask;
        logic [1:0]        pos;
        logic [1:0]        lane_sel;
        logic [DATA_W-1:0] packed_word;
        logic [3:0]        field;
        logic [1:0]        ndev_lg;

        rd_m1     = (rd_lg == 2'd0) ? 2'd0 : ((rd_lg == 2'd1) ? 2'd1 : 2'd3);
        bank_mask = (bank_lg == 2'd0) ? 2'd0 : ((bank_lg == 2'd1) ? 2'd1 : 2'd3);

        packed_word = '0;
        for (int b = 0; b < LANES; b++) begin
            pos      = 2'(b);
            lane_sel = pos >> bank_lg;
            if (pos <= rd_m1) begin
                packed_word[8*b +: 8] = lane_resp[lane_sel][8*int'(pos & bank_mask) +: 8];
            end
        end

        field   = (bank_lg == 2'd0) ? 4'd8 : 4'd11;
        ndev_lg = (bank_lg >= dev_lg) ? (bank_lg - dev_lg) : 2'd0;

        st_d.valid = rd_en;
        st_d.data  = rd_en ? packed_word : '0;
        st_d.blk   = BLK_W'(1) << (field + {2'd0, ndev_lg});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid      = st_q.valid;
    assign rd_data       = st_q.data;
    assign buf_blk_bytes = st_q.blk;
endmodule

// File: rtl/flash_query_resp_chk.sv
module flash_query_resp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [1:0]  mode,
    input logic [1:0]  bank_lg,
    input logic [1:0]  dev_lg,
    input logic [1:0]  maxdev_lg,
    input logic [1:0]  rd_lg,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic [13:0] buf_blk_bytes
);
    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R2
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode != 2'd1 && mode != 2'd2) |=> rd_data == 32'd0);

    // R9
    narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_lg == 2'd0) |=> rd_data[31:8] == 24'd0);

    // R6
    unsupported_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == 2'd2 && dev_lg == 2'd1 && maxdev_lg == 2'd2 && rd_lg <= bank_lg)
        |=> rd_data == 32'd0);

    // R10
    blk_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $countones(buf_blk_bytes) == 1);
endmodule

bind flash_query_resp flash_query_resp_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (rd_en),
    .mode          (mode),
    .bank_lg       (bank_lg),
    .dev_lg        (dev_lg),
    .maxdev_lg     (maxdev_lg),
    .rd_lg         (rd_lg),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .buf_blk_bytes (buf_blk_bytes)
);

// File: tb/flash_query_resp_tb.sv
module flash_query_resp_tb;
    localparam int M_ID = 32'h0000_0089;
    localparam int D_ID = 32'h0000_0018;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] byte_off = '0;
    logic [1:0]  bank_lg = 2'd0, dev_lg = 2'd0, maxdev_lg = 2'd0, rd_lg = 2'd0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [13:0] buf_blk_bytes;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flash_query_resp u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mode(mode), .byte_off(byte_off),
        .bank_lg(bank_lg), .dev_lg(dev_lg), .maxdev_lg(maxdev_lg), .rd_lg(rd_lg),
        .rd_valid(rd_valid), .rd_data(rd_data), .buf_blk_bytes(buf_blk_bytes)
    );

    function automatic int tbl(int i, int bl);
        int v;
        v = 0;
        if (i == 16) v = 81;
        if (i == 17) v = 82;
        if (i == 18) v = 89;
        if (i == 19) v = 1;
        if (i == 21) v = 49;
        if (i == 27) v = 69;
        if (i == 28) v = 85;
        if (i == 31 || i == 32) v = 7;
        if (i == 33) v = 10;
        if (i >= 35 && i <= 37) v = 4;
        if (i == 39) v = 22;
        if (i == 40) v = 2;
        if (i == 42) v = (bl == 0) ? 8 : 11;
        if (i == 44) v = 1;
        if (i == 45) v = 63;
        if (i == 48) v = 1;
        if (i == 49) v = 80;
        if (i == 50) v = 82;
        if (i == 51) v = 73;
        if (i == 52) v = 49;
        return v;
    endfunction

    function automatic logic [31:0] bytes_mask(int n);
        return (n >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * n)) - 32'd1);
    endfunction

    function automatic logic [31:0] m_lookup(int off, int md, int bl, int dl, int ml);
        int idx, bank, dev;
        logic [31:0] unit, r;
        bank = 1 << bl;
        dev  = 1 << dl;
        idx  = (off & 16'hFFFF) >> (bl + ml - dl);
        unit = 0;
        r    = 0;
        if (md == 2) begin
            if (idx >= 82) return 0;
            if (dl != ml) begin
                if (dl != 0) return 0;
                for (int b = 0; b < bank; b++) r |= 32'(tbl(idx, bl)) << (8 * b);
                return r;
            end
            unit = 32'(tbl(idx, bl));
        end else if (md == 1) begin
            if ((idx % 256) == 0) unit = M_ID;
            else if ((idx % 256) == 1) unit = D_ID;
            unit &= bytes_mask(dev);
        end else begin
            return 0;
        end
        for (int p = 0; p < bank; p += dev) r |= unit << (8 * p);
        return r & bytes_mask(bank);
    endfunction

    function automatic logic [31:0] m_read(int off, int md, int bl, int dl, int ml, int rl);
        int bank, rb;
        logic [31:0] r;
        bank = 1 << bl;
        rb   = 1 << rl;
        r    = 0;
        if (rb <= bank) return m_lookup(off, md, bl, dl, ml) & bytes_mask(rb);
        for (int k = 0; k < rb / bank; k++)
            r |= m_lookup(off + k * bank, md, bl, dl, ml) << (8 * k * bank);
        return r;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic en, int md, int off, int bl, int dl, int ml, int rl);
        logic [31:0] e_data;
        int          e_blk;
        @(negedge clk);
        rd_en = en; mode = 2'(md); byte_off = 16'(off);
        bank_lg = 2'(bl); dev_lg = 2'(dl); maxdev_lg = 2'(ml); rd_lg = 2'(rl);
        e_data = en ? m_read(off, md, bl, dl, ml, rl) : 32'd0;
        e_blk  = (1 << ((bl == 0) ? 8 : 11)) * ((1 << bl) / (1 << dl));
        @(posedge clk);
        #1;
        check(tag, "valid", 32'(rd_valid), 32'(en));
        check(tag, "data", rd_data, e_data);
        check("R10", "blk", 32'(buf_blk_bytes), 32'(e_blk));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "valid in reset", 32'(rd_valid), 0);
        check("R1", "data in reset", rd_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "valid after reset", 32'(rd_valid), 0);
        check("R1", "data after reset", rd_data, 0);

        // R5 query table contents, 1-byte bank
        step("R5", 1, 2, 16'h10, 0, 0, 0, 0);
        step("R5", 1, 2, 16'h11, 0, 0, 0, 0);
        step("R5", 1, 2, 16'h12, 0, 0, 0, 0);
        step("R5", 1, 2, 16'h2C, 0, 0, 0, 0);
        step("R5", 1, 2, 16'h2A, 0, 0, 0, 0);
        step("R5", 1, 2, 16'h2A << 1, 1, 1, 1, 1);
        // R3 index shift: bank 2, dev 1, max 2 -> shift 2
        step("R3", 1, 2, 16'h40, 1, 0, 1, 1);
        step("R3", 1, 2, 16'h2C << 2, 1, 0, 1, 1);
        // R6 byte mode and unsupported mix
        step("R6", 1, 2, 16'h44, 2, 0, 1, 2);
        step("R6", 1, 2, 16'h10 << 2, 2, 1, 2, 2);
        // R7 slice replication
        step("R7", 1, 2, 16'h40, 2, 1, 1, 2);
        step("R7", 1, 2, 16'h4C, 2, 0, 0, 2);
        // R4 out-of-range index, including aliasing low bits
        step("R4", 1, 2, 16'h52, 0, 0, 0, 0);
        step("R4", 1, 2, 16'h112, 0, 0, 0, 0);
        step("R4", 1, 2, 16'h110 << 1, 1, 1, 1, 1);
        // R8 identifier mode
        step("R8", 1, 1, 0, 1, 0, 0, 1);
        step("R8", 1, 1, 2, 1, 0, 0, 1);
        step("R8", 1, 1, 4, 1, 0, 0, 1);
        step("R8", 1, 1, 16'h200, 1, 0, 0, 1);
        step("R8", 1, 1, 4, 2, 1, 1, 2);
        step("R8", 1, 1, 0, 2, 2, 2, 2);
        // R9 wide and narrow reads
        step("R9", 1, 2, 16'h10, 0, 0, 0, 2);
        step("R9", 1, 2, 16'h20, 1, 1, 1, 2);
        step("R9", 1, 1, 0, 0, 0, 0, 1);
        step("R9", 1, 2, 16'h40, 2, 1, 1, 0);
        // R2 idle and other modes
        step("R2", 0, 2, 16'h10, 0, 0, 0, 0);
        step("R2", 1, 0, 16'h10, 0, 0, 0, 2);
        step("R2", 1, 3, 16'h10, 0, 0, 0, 2);

        // R7 R8 R9 mixed traffic over legal width settings
        for (int n = 0; n < 400; n++) begin
            int bl, dl, ml, rl, md, off;
            bl  = int'($urandom_range(0, 2));
            dl  = int'($urandom_range(0, bl));
            ml  = int'($urandom_range(dl, 2));
            rl  = int'($urandom_range(0, 2));
            md  = int'($urandom_range(0, 3));
            off = int'($urandom_range(0, 16'h3FF));
            step("R7", ($urandom_range(0, 7) != 0), md, off, bl, dl, ml, rl);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule